// File: doc/BRIEF.md
# Video Format and Frame Lock Detector

This block sits behind a word-alignment stage in a serial video receiver. It counts the lines that fall inside the active region of each field or frame. It pairs that count with the words-per-line figure supplied by the alignment stage. It then identifies the raster by walking a small built-in table of known formats, one entry per clock.

A table hit raises the frame-locked flag and reports the entry's index. A raster that is not in the table can still be locked: this happens once two back-to-back fields carry identical counts, and the format output then shows a reserved "unknown" code. The counts accepted at lock become the reference for the fields that follow.

While locked, a field whose counts differ from the reference is tolerated up to a parameterised number of times in a row. One further consecutive difference drops lock. Whenever the upstream alignment lock is low, the block forgets everything and reports no lock.

Top module: `vfmt_lock_detect`

## Requirements
- R1: While reset is high, and in the cycle after it, `frame_locked` is 0 and `fmt_idx` holds the unknown code (all ones, 7 for the default 3-bit index).
- R2: The line count of a field is the number of `sol` pulses seen while `act` is high. Pulses while `act` is low do not change it. A field ends on the cycle where `act` goes from 1 to 0.
- R3: With the defaults, the table holds four entries. Index 0 is 2200 words by 1080 lines, index 1 is 1650 by 720, index 2 is 1728 by 288, and index 3 is 858 by 244. An unlocked field that equals an entry in both words and lines sets `frame_locked` and reports that index.
- R4: A field that equals an entry in only one of the two counts is not a match.
- R5: An unlocked field that matches no entry but equals the previous field in both counts sets `frame_locked` with the unknown code. The first field of such a pair leaves the block unlocked.
- R6: While locked, up to MISS_TOL (default 4) consecutive fields that differ from the reference keep `frame_locked` and `fmt_idx` unchanged. The next consecutive differing field clears lock, sets the unknown code, and makes that field the new reference.
- R7: While locked, a field equal to the reference clears the count of consecutive differing fields.
- R8: When `trs_locked` is low, `frame_locked` is 0 and `fmt_idx` is the unknown code from the next cycle on. The reference is also discarded, so after `trs_locked` returns, a single unknown field does not lock.
- R9: The table search visits one entry per clock. Outputs change only in the cycle after a search finishes, which is at most N_FMT+2 cycles after a field ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sol | input | 1 | One-cycle pulse at the start of every line |
| act | input | 1 | High from the first to the last active line of a field |
| wpl | input | WPL_W | Words per line from the alignment stage |
| trs_locked | input | 1 | Upstream word-alignment lock |
| frame_locked | output | 1 | Raster identified and stable |
| fmt_idx | output | IDX_W | Matched table index, or all ones when unknown |

## Verification
A field's verdict is due at most N_FMT+3 clocks after `act` falls. That delay covers the field-end register, at most N_FMT search steps, and the decision register. The scoreboard monitor samples 20 falling edges after the driver queues each expectation, and the driver keeps all inputs quiet for 40 cycles afterwards, so the sample never overlaps the next field. The effect of dropping `trs_locked` is due one edge later, and it is sampled well inside the window in which the input is held low.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  // Number of entries the built-in raster table can provide.
  localparam int unsigned TABLE_DEPTH = 6;

  // Words per line of each known raster.
  function automatic int unsigned tbl_words(input int unsigned i);
    case (i)
      0: return 2200;
      1: return 1650;
      2: return 1728;
      3: return 858;
      4: return 2640;
      5: return 1980;
      default: return 0;
    endcase
  endfunction

  // Active lines per field or frame of each known raster.
  function automatic int unsigned tbl_lines(input int unsigned i);
    case (i)
      0: return 1080;
      1: return 720;
      2: return 288;
      3: return 244;
      4: return 1080;
      5: return 720;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/vfd_line_meter.sv
module vfd_line_meter #(
  parameter int WPL_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trs_locked,
  input  logic              sol,
  input  logic              act,
  input  logic [WPL_W-1:0]  wpl,
  output logic              field_done,
  output logic [WPL_W-1:0]  meas_words,
  output logic [LINE_W-1:0] meas_lines
);

  logic              act_q;
  logic [LINE_W-1:0] line_cnt;
  logic              field_end;

  assign field_end = act_q && !act;

  always_ff @(posedge clk) begin
    if (rst || !trs_locked) begin
      act_q      <= 1'b0;
      line_cnt   <= '0;
      field_done <= 1'b0;
      meas_words <= '0;
      meas_lines <= '0;
    end else begin
      act_q      <= act;
      field_done <= field_end;
      if (field_end) begin
        meas_lines <= line_cnt;
        meas_words <= wpl;
        line_cnt   <= '0;
      end else if (sol && act) begin
        line_cnt <= line_cnt + 1'b1;
      end
    end
  end

  // R2: the count only moves on an active-line pulse or at field end
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    (trs_locked && !(sol && act) && !field_end) |=> $stable(line_cnt));

  // R2: a field end produces exactly one completion pulse
  a_r2_single_done: assert property (@(posedge clk) disable iff (rst)
    field_done |=> !field_done);

endmodule

// File: rtl/vfd_table_search.sv
module vfd_table_search
  import vfd_pkg::*;
#(
  parameter int WPL_W  = 12,
  parameter int LINE_W = 11,
  parameter int N_FMT  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic [WPL_W-1:0]  meas_words,
  input  logic [LINE_W-1:0] meas_lines,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [WPL_W-1:0]  cur_w;
  logic [LINE_W-1:0] cur_l;
  logic              entry_eq;
  logic              last;

  always_comb begin
    cur_w    = WPL_W'(tbl_words(32'(idx)));
    cur_l    = LINE_W'(tbl_lines(32'(idx)));
    entry_eq = (cur_w == meas_words) && (cur_l == meas_lines);
    last     = (idx == IDX_W'(N_FMT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      done <= 1'b0;
      hit  <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (entry_eq) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          hit     <= 1'b1;
          hit_idx <= idx;
        end else if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R9: a started search is running on the next cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst || abort)
    start |=> busy);

  // R9: the walk never leaves the table
  a_r9_idx_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx < IDX_W'(N_FMT)));

  // R3, R4: a reported hit equals the measured counts in both dimensions
  a_r3_hit_equal: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |->
      (WPL_W'(tbl_words(32'(hit_idx))) == meas_words) &&
      (LINE_W'(tbl_lines(32'(hit_idx))) == meas_lines));

endmodule

// File: rtl/vfd_lock_ctrl.sv
module vfd_lock_ctrl #(
  parameter int WPL_W    = 12,
  parameter int LINE_W   = 11,
  parameter int IDX_W    = 3,
  parameter int MISS_TOL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trs_locked,
  input  logic              done,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [WPL_W-1:0]  meas_words,
  input  logic [LINE_W-1:0] meas_lines,
  output logic              frame_locked,
  output logic [IDX_W-1:0]  fmt_idx
);

  localparam logic [IDX_W-1:0] UNK = {IDX_W{1'b1}};
  localparam int MW = (MISS_TOL < 1) ? 1 : $clog2(MISS_TOL + 1);

  logic              ref_valid;
  logic [WPL_W-1:0]  ref_w;
  logic [LINE_W-1:0] ref_l;
  logic [MW-1:0]     miss_cnt;
  logic              same_ref;

  assign same_ref = ref_valid && (ref_w == meas_words) && (ref_l == meas_lines);

  always_ff @(posedge clk) begin
    if (rst || !trs_locked) begin
      frame_locked <= 1'b0;
      fmt_idx      <= UNK;
      ref_valid    <= 1'b0;
      ref_w        <= '0;
      ref_l        <= '0;
      miss_cnt     <= '0;
    end else if (done) begin
      if (frame_locked) begin
        if (same_ref) begin
          miss_cnt <= '0;
        end else if (miss_cnt == MW'(MISS_TOL)) begin
          frame_locked <= 1'b0;
          fmt_idx      <= UNK;
          miss_cnt     <= '0;
          ref_w        <= meas_words;
          ref_l        <= meas_lines;
        end else begin
          miss_cnt <= miss_cnt + 1'b1;
        end
      end else begin
        ref_w     <= meas_words;
        ref_l     <= meas_lines;
        ref_valid <= 1'b1;
        miss_cnt  <= '0;
        if (hit) begin
          frame_locked <= 1'b1;
          fmt_idx      <= hit_idx;
        end else if (same_ref) begin
          frame_locked <= 1'b1;
          fmt_idx      <= UNK;
        end
      end
    end
  end

  // R1: reset leaves the outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!frame_locked && fmt_idx == UNK));

  // R8: loss of alignment lock clears the outputs on the next cycle
  a_r8_trs_off: assert property (@(posedge clk) disable iff (rst)
    !trs_locked |=> (!frame_locked && fmt_idx == UNK));

  // R9: outputs only move after a search verdict (or a lock loss)
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (!done && trs_locked) |=>
      (!trs_locked || ($stable(frame_locked) && $stable(fmt_idx))));

  // R6: the consecutive-difference count never exceeds the tolerance
  a_r6_miss_bound: assert property (@(posedge clk) disable iff (rst)
    miss_cnt <= MW'(MISS_TOL));

endmodule

// File: rtl/vfmt_lock_detect.sv
module vfmt_lock_detect
  import vfd_pkg::*;
#(
  parameter int WPL_W    = 12,
  parameter int LINE_W   = 11,
  parameter int N_FMT    = 4,
  parameter int MISS_TOL = 4,
  parameter int IDX_W    = $clog2(N_FMT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sol,
  input  logic              act,
  input  logic [WPL_W-1:0]  wpl,
  input  logic              trs_locked,
  output logic              frame_locked,
  output logic [IDX_W-1:0]  fmt_idx
);

  logic              field_done;
  logic [WPL_W-1:0]  meas_words;
  logic [LINE_W-1:0] meas_lines;
  logic              srch_done;
  logic              srch_hit;
  logic [IDX_W-1:0]  srch_idx;

  initial begin
    if (N_FMT < 1 || N_FMT > int'(TABLE_DEPTH))
      $error("N_FMT out of range");
  end

  vfd_line_meter #(.WPL_W(WPL_W), .LINE_W(LINE_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .trs_locked (trs_locked),
    .sol        (sol),
    .act        (act),
    .wpl        (wpl),
    .field_done (field_done),
    .meas_words (meas_words),
    .meas_lines (meas_lines)
  );

  vfd_table_search #(.WPL_W(WPL_W), .LINE_W(LINE_W), .N_FMT(N_FMT), .IDX_W(IDX_W)) u_search (
    .clk        (clk),
    .rst        (rst),
    .abort      (!trs_locked),
    .start      (field_done),
    .meas_words (meas_words),
    .meas_lines (meas_lines),
    .done       (srch_done),
    .hit        (srch_hit),
    .hit_idx    (srch_idx)
  );

  vfd_lock_ctrl #(.WPL_W(WPL_W), .LINE_W(LINE_W), .IDX_W(IDX_W), .MISS_TOL(MISS_TOL)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .trs_locked   (trs_locked),
    .done         (srch_done),
    .hit          (srch_hit),
    .hit_idx      (srch_idx),
    .meas_words   (meas_words),
    .meas_lines   (meas_lines),
    .frame_locked (frame_locked),
    .fmt_idx      (fmt_idx)
  );

endmodule

// File: tb/vfmt_lock_detect_tb.sv
module vfmt_lock_detect_tb;

  localparam int WPL_W = 12;
  localparam int LINE_W = 11;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] UNK = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sol = 1'b0;
  logic act = 1'b0;
  logic [WPL_W-1:0] wpl = '0;
  logic trs_locked = 1'b0;
  logic frame_locked;
  logic [IDX_W-1:0] fmt_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic             lk;
    logic [IDX_W-1:0] fmt;
    string            tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  vfmt_lock_detect #(.WPL_W(WPL_W), .LINE_W(LINE_W), .N_FMT(4), .MISS_TOL(4)) u_dut (
    .clk(clk), .rst(rst), .sol(sol), .act(act), .wpl(wpl),
    .trs_locked(trs_locked), .frame_locked(frame_locked), .fmt_idx(fmt_idx)
  );

  task automatic expect_out(input logic lk, input logic [IDX_W-1:0] fmt, input string tag);
    exp_t e;
    e.lk = lk; e.fmt = fmt; e.tag = tag;
    expq.push_back(e);
    repeat (40) @(negedge clk);
  endtask

  task automatic send_field(input int words, input int lines, input bit blank_pulses,
                            input logic lk, input logic [IDX_W-1:0] fmt, input string tag);
    wpl = WPL_W'(words);
    if (blank_pulses) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk) sol = 1'b1;
        @(negedge clk) sol = 1'b0;
      end
    end
    for (int l = 0; l < lines; l++) begin
      @(negedge clk); act = 1'b1; sol = 1'b1;
      @(negedge clk); sol = 1'b0;
      @(negedge clk);
    end
    @(negedge clk) act = 1'b0;
    expect_out(lk, fmt, tag);
  endtask

  // monitor: compare each queued expectation once its result is due
  initial begin
    forever begin
      exp_t e;
      wait (expq.size() > 0);
      repeat (20) @(negedge clk);
      e = expq.pop_front();
      checks++;
      if (frame_locked !== e.lk || fmt_idx !== e.fmt) begin
        errors++;
        $display("FAIL %s: actual locked=%0b fmt=%0d expected locked=%0b fmt=%0d",
                 e.tag, frame_locked, fmt_idx, e.lk, e.fmt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    trs_locked = 1'b1;
    expect_out(1'b0, UNK, "R1 reset state");
    // R2: blanking pulses ignored, so 288 lines still matches entry 2
    send_field(1728, 288, 1'b1, 1'b1, 3'd2, "R2 R3 lock on entry 2");
    for (int i = 1; i <= 4; i++)
      send_field(858, 244, 1'b0, 1'b1, 3'd2, "R6 tolerated difference");
    send_field(858, 244, 1'b0, 1'b0, UNK, "R6 fifth difference drops lock");
    send_field(858, 244, 1'b0, 1'b1, 3'd3, "R3 relock on entry 3");
    send_field(858, 288, 1'b0, 1'b1, 3'd3, "R6 difference 1");
    send_field(1728, 288, 1'b0, 1'b1, 3'd3, "R6 difference 2");
    send_field(858, 244, 1'b0, 1'b1, 3'd3, "R7 reference field clears count");
    for (int i = 1; i <= 4; i++)
      send_field(1728, 288, 1'b0, 1'b1, 3'd3, "R7 count restarted");
    send_field(1728, 288, 1'b0, 1'b0, UNK, "R6 drop after restart");
    send_field(1728, 288, 1'b0, 1'b1, 3'd2, "R3 relock on entry 2");
    @(negedge clk) trs_locked = 1'b0;
    expect_out(1'b0, UNK, "R8 trs low clears lock");
    trs_locked = 1'b1;
    repeat (5) @(negedge clk);
    send_field(500, 100, 1'b0, 1'b0, UNK, "R5 first unknown field");
    send_field(500, 100, 1'b0, 1'b1, UNK, "R5 stable unknown locks");
    @(negedge clk) trs_locked = 1'b0;
    expect_out(1'b0, UNK, "R8 trs low clears unknown lock");
    trs_locked = 1'b1;
    repeat (5) @(negedge clk);
    send_field(500, 100, 1'b0, 1'b0, UNK, "R8 reference discarded");
    send_field(858, 288, 1'b0, 1'b0, UNK, "R4 words only match");
    send_field(1728, 244, 1'b0, 1'b0, UNK, "R4 lines only match");
    send_field(1728, 244, 1'b0, 1'b1, UNK, "R5 repeat of unmatched field");
    wait (expq.size() == 0);
    repeat (25) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule